// File: doc/BRIEF.md
# DC-Removal Filter with Freeze

This block sits after a decimation stage and removes the DC component from a stream of signed 24-bit samples. Each accepted sample, marked by a valid strobe, has a running offset estimate subtracted from it. The result is registered and leaves one clock later with its own valid strobe. The estimate is a leaky integrator held in fixed point with extra fraction bits. Each update moves it toward the incoming sample by an arithmetic right shift of the difference.

A freeze input stops the estimate from moving without removing it from the signal path. While freeze is high, every sample still has the stored offset taken off. This lets a steady input be measured against a fixed offset. Freeze can be raised or dropped at any time, and doing so never changes the stored value.

Top module: `dcrm_filter`

## Requirements
- R1: For each accepted sample, the output is the sample minus the integer part of the estimate as it stood before that sample. The integer part is the estimate's fixed-point value shifted right arithmetically by FRAC_W, which is floor rounding.
- R2: With freeze at 0, each accepted sample x updates the fixed-point estimate e to e + (((x << FRAC_W) - e) >>> SHIFT_K), with an arithmetic (floor) shift.
- R3: With freeze at 1, an accepted sample leaves the estimate unchanged, and the held estimate is still subtracted from that sample.
- R4: Changing freeze, and cycles without in_valid, have no effect on the stored estimate. While in_valid is low, out_data keeps its last value.
- R5: The difference saturates to the signed 24-bit range: results above 8388607 give 8388607, and results below -8388608 give -8388608.
- R6: Reset, active low, clears the estimate, out_valid and out_data to zero.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high, and out_data carries that sample's result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 24 | Signed input sample |
| freeze | input | 1 | High: hold the offset estimate |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | 24 | Signed, saturated, DC-removed sample |

## Verification
Some properties are checked on every cycle. The result strobe follows the sample strobe by exactly one clock. The estimate stays put when the input is idle or freeze is high. The saturating subtractor never wraps: a non-negative sample minus a non-positive offset always yields a non-negative result, and the mirrored case yields a negative one. The bench's scenarios cover the rest. These are the exact update arithmetic with its floor rounding, convergence toward a constant input, clipping at both range limits after the estimate has been driven to an extreme, and the offset staying the same across freeze toggles and a mid-run reset.

// File: rtl/dcrm_pkg.sv
package dcrm_pkg;
    localparam int unsigned DEF_DATA_W  = 24;
    localparam int unsigned DEF_FRAC_W  = 10;
    localparam int unsigned DEF_SHIFT_K = 10;
endpackage

// File: rtl/dcrm_estimator.sv
module dcrm_estimator #(
    parameter int unsigned DATA_W  = dcrm_pkg::DEF_DATA_W,
    parameter int unsigned FRAC_W  = dcrm_pkg::DEF_FRAC_W,
    parameter int unsigned SHIFT_K = dcrm_pkg::DEF_SHIFT_K,
    localparam int unsigned ACC_W  = DATA_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_data,
    input  logic                     hold,
    output logic signed [DATA_W-1:0] est_whole,
    output logic signed [ACC_W-1:0]  est_fx
);
    localparam int unsigned DIF_W = ACC_W + 1;

    typedef struct packed {
        logic signed [ACC_W-1:0] est;
    } est_state_t;

    est_state_t st_d, st_q;

    logic signed [DIF_W-1:0] x_fx_d;
    logic signed [DIF_W-1:0] est_ext_d;
    logic signed [DIF_W-1:0] gap_d;
    logic signed [DIF_W-1:0] step_d;
    logic signed [DIF_W-1:0] sum_d;

    always_comb begin
        x_fx_d    = $signed({smp_data[DATA_W-1], smp_data, {FRAC_W{1'b0}}});
        est_ext_d = $signed({st_q.est[ACC_W-1], st_q.est});
        gap_d     = x_fx_d - est_ext_d;
        step_d    = gap_d >>> SHIFT_K;
        sum_d     = est_ext_d + step_d;
        st_d      = st_q;
        if (smp_valid && !hold) begin
            st_d.est = sum_d[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign est_fx    = st_q.est;
    assign est_whole = st_q.est[ACC_W-1:FRAC_W];
endmodule

// File: rtl/dcrm_sub_sat.sv
module dcrm_sub_sat #(
    parameter int unsigned DATA_W = dcrm_pkg::DEF_DATA_W
) (
    input  logic signed [DATA_W-1:0] minuend,
    input  logic signed [DATA_W-1:0] subtrahend,
    output logic signed [DATA_W-1:0] result
);
    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W:0] wide_d;
    logic                   ovf_d;

    always_comb begin
        wide_d = $signed({minuend[DATA_W-1], minuend})
               - $signed({subtrahend[DATA_W-1], subtrahend});
        ovf_d  = wide_d[DATA_W] ^ wide_d[DATA_W-1];
        if (ovf_d) begin
            result = wide_d[DATA_W] ? NEG_LIM : POS_LIM;
        end else begin
            result = wide_d[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/dcrm_filter.sv
module dcrm_filter #(
    parameter int unsigned DATA_W  = dcrm_pkg::DEF_DATA_W,
    parameter int unsigned FRAC_W  = dcrm_pkg::DEF_FRAC_W,
    parameter int unsigned SHIFT_K = dcrm_pkg::DEF_SHIFT_K
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              freeze,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned ACC_W = DATA_W + FRAC_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t os_d, os_q;

    logic signed [DATA_W-1:0] est_whole;
    logic signed [ACC_W-1:0]  est_fx;
    logic signed [DATA_W-1:0] diff_sat;

    dcrm_estimator #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .SHIFT_K(SHIFT_K)
    ) u_est (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(in_valid),
        .smp_data ($signed(in_data)),
        .hold     (freeze),
        .est_whole(est_whole),
        .est_fx   (est_fx)
    );

    dcrm_sub_sat #(
        .DATA_W(DATA_W)
    ) u_sub (
        .minuend   ($signed(in_data)),
        .subtrahend(est_whole),
        .result    (diff_sat)
    );

    always_comb begin
        os_d       = os_q;
        os_d.valid = in_valid;
        if (in_valid) begin
            os_d.data = diff_sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign out_valid = os_q.valid;
    assign out_data  = os_q.data;
endmodule

// File: rtl/dcrm_filter_chk.sv
module dcrm_filter_chk #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ACC_W  = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              freeze,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [ACC_W-1:0]  est_fx
);
    // R7: strobe follows input strobe by one clock
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: frozen samples leave the estimate alone
    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && freeze) |=> $stable(est_fx));
    // R4: idle cycles leave the estimate alone
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(est_fx));
    // R5: no wrap-around in either direction
    a_r5_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_data[DATA_W-1] && est_fx[ACC_W-1]) |=> !out_data[DATA_W-1]);
    a_r5_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[DATA_W-1] && !est_fx[ACC_W-1]) |=> out_data[DATA_W-1]);
endmodule

bind dcrm_filter dcrm_filter_chk #(
    .DATA_W(DATA_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .freeze   (freeze),
    .out_valid(out_valid),
    .out_data (out_data),
    .est_fx   (est_fx)
);

// File: tb/sim_dcrm_filter.sv
module sim_dcrm_filter;
    localparam int DW   = 24;
    localparam int FRAC = 8;
    localparam int K    = 4;
    localparam longint PMAX = 64'sd8388607;
    localparam longint NMIN = -64'sd8388608;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          freeze = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int     checks = 0;
    int     failures = 0;
    bit     done = 0;
    longint est_m = 0;
    longint last_y = 0;

    always #10 clk = ~clk;

    dcrm_filter #(.DATA_W(DW), .FRAC_W(FRAC), .SHIFT_K(K)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .freeze(freeze), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint clip(input longint v);
        if (v > PMAX) return PMAX;
        if (v < NMIN) return NMIN;
        return v;
    endfunction

    function automatic longint as_int(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge after checking.
    task automatic send(input longint x, input logic frz, input string req);
        longint y;
        in_valid = 1'b1;
        in_data  = x[DW-1:0];
        freeze   = frz;
        y = clip(x - (est_m >>> FRAC));
        if (!frz) est_m = est_m + (((x <<< FRAC) - est_m) >>> K);
        last_y = y;
        @(negedge clk);
        check("R7 out_valid", longint'(out_valid), 1);
        check(req, as_int(out_data), y);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_data = $urandom;
            freeze  = $urandom_range(0, 1);
            @(negedge clk);
            check("R7 idle out_valid", longint'(out_valid), 0);
            check("R4 idle out_data held", as_int(out_data), last_y);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 reset out_valid", longint'(out_valid), 0);
        check("R6 reset out_data", as_int(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first sample sees a zero estimate
        send(12345, 1'b0, "R1 first sample");
        send(-700000, 1'b0, "R2 update step");
        send(-700000, 1'b0, "R2 update step 2");
        idle(3);
        // R3: frozen constant input gives constant output
        send(1000, 1'b1, "R3 frozen subtract");
        begin
            longint first;
            first = as_int(out_data);
            send(1000, 1'b1, "R3 frozen subtract again");
            check("R3 frozen output unchanged", as_int(out_data), first);
        end
        // R4: toggle freeze while idle, then resume
        idle(5);
        send(0, 1'b0, "R4 estimate kept across toggles");
        // R5 positive clip: drive estimate toward most negative value
        for (int i = 0; i < 80; i++) send(NMIN, 1'b0, "R2 converge low");
        send(PMAX, 1'b1, "R5 clip high");
        check("R5 clip high value", as_int(out_data), PMAX);
        // R5 negative clip
        for (int i = 0; i < 120; i++) send(PMAX, 1'b0, "R2 converge high");
        send(NMIN, 1'b1, "R5 clip low");
        check("R5 clip low value", as_int(out_data), NMIN);
        // R6 mid-run reset
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 mid reset out_valid", longint'(out_valid), 0);
        check("R6 mid reset out_data", as_int(out_data), 0);
        rst_n = 1'b1;
        est_m = 0;
        last_y = 0;
        @(negedge clk);
        send(-4321, 1'b0, "R6 estimate cleared");
        // Random mix
        for (int i = 0; i < 1500; i++) begin
            longint x;
            x = as_int(24'($urandom));
            if ($urandom_range(0, 3) == 0) x = x >>> 12;
            send(x, ($urandom_range(0, 4) == 0), "R1 random sample");
            if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
        end
        idle(2);
        finish_run();
    end
endmodule